// File: doc/BRIEF.md
# Wake-up event controller

This block gathers the wake-up sources of a network controller and turns them into one wake request. Three sources arrive as single-cycle strobes from logic elsewhere: a link-state change, a sample-frame match and a magic-packet reception. The fourth source is a sideband clock pin that is watched for a slow, deliberate pattern. The pin must sit low for a full window of milliseconds and then sit high for a full window of the same length. A prescaler turns the core clock into a millisecond tick, and both the window length and the prescale ratio are parameters.

Each source has an enable bit that software can write and a sticky status bit that software can only read or clear. The eight bits are gathered into one byte on a simple read/write bus. Status bits clear through a separate write-one-to-clear strobe and mask. An active-low power-on reset clears everything. A synchronous software reset clears everything except the sample-frame and magic-packet status bits, so a wake cause seen before the reset is still visible after it.

Top module: `wake_evt_ctrl`

## Requirements
- R1: After power-on reset (`rstPorN` low), `regRdata` reads 8'h00 and `wakeReq` is 0.
- R2: A cycle with `regWr` high loads enable bits from `regWdata`. The byte layout is: bit 7 pin enable, bit 6 pin status, bit 5 link enable, bit 4 link status, bit 3 sample enable, bit 2 sample status, bit 1 magic enable, bit 0 magic status. The new enables read back on `regRdata` after that clock edge.
- R3: A bus write has no effect on the status bits (6, 4, 2, 0), whatever `regWdata` holds.
- R4: An event strobe sets its status bit at the next clock edge, whether or not its enable bit is set.
- R5: `wakeReq` is 1 exactly when some source has both its enable bit and its status bit set.
- R6: A cycle with `clrStb` high clears each status bit whose `clrMask` bit is 1 (mask bit 3 pin, bit 2 link, bit 1 sample, bit 0 magic) at the next edge. Mask bits that are 0 leave their status bits unchanged.
- R7: If an event strobe and a clear of the same status bit fall in the same cycle, the bit ends up set.
- R8: A cycle with `swRst` high clears all four enable bits and the pin and link status bits. The sample and magic status bits keep their value, or become set if their event strobe arrives in that cycle. For pin and link, the software reset wins over a same-cycle event.
- R9: After a two-flop synchroniser, the pin is low for `WINDOW_MS` millisecond ticks (`CLK_PER_MS` clocks each) and then high for `WINDOW_MS` ticks. When this happens, the pin status bit sets.
- R10: A high level on the pin before the low window has run out restarts the low count, so a broken low phase never produces a pin event.
- R11: A low level on the pin before the high window has run out sends detection back to the low phase, so a broken high phase produces no pin event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstPorN | input | 1 | Asynchronous power-on reset, active low |
| swRst | input | 1 | Synchronous software reset, active high |
| pinIn | input | 1 | Sideband clock pin, asynchronous |
| linkEvt | input | 1 | Link-state change strobe |
| sampleEvt | input | 1 | Sample-frame match strobe |
| magicEvt | input | 1 | Magic-packet strobe |
| regWr | input | 1 | Register write strobe (enables only) |
| regWdata | input | 8 | Register write data |
| clrStb | input | 1 | Status clear strobe |
| clrMask | input | 4 | Status bits to clear: 3 pin, 2 link, 1 sample, 0 magic |
| regRdata | output | 8 | Register read data |
| wakeReq | output | 1 | Wake request |

## Verification
Two of the block's functions can hit the same status bit in the same cycle: an arriving event against a clear from software, and an event against a software reset. The bench provokes both. Directed cycles drive a strobe together with a matching clear bit, or together with `swRst`. Random cycles draw every strobe, clear mask, write and software reset independently, so these overlaps also occur many times. A bench model predicts the next value of every bit using the stated precedence (software reset for pin and link, then event, then clear). After each edge, `regRdata` and `wakeReq` are compared with that model.

// File: rtl/wake_pkg.sv
package wake_pkg;
  localparam int NSRC = 4;
  localparam int SRC_MAGIC  = 0;
  localparam int SRC_SAMPLE = 1;
  localparam int SRC_LINK   = 2;
  localparam int SRC_PIN    = 3;

  // status bits that survive a software reset
  localparam logic [NSRC-1:0] SOFT_KEEP = 4'b0011;

  typedef struct packed {
    logic [NSRC-1:0] setStat;
    logic [NSRC-1:0] clrStat;
    logic [NSRC-1:0] dropStat;
    logic            enLoad;
    logic            enDrop;
    logic [NSRC-1:0] enVal;
  } wake_strb_t;

  typedef enum logic [1:0] {PH_LOW, PH_ARMED, PH_HIGH} pin_phase_e;
endpackage

// File: rtl/wake_pin_det.sv
module wake_pin_det
  import wake_pkg::*;
#(
  parameter int CLK_PER_MS = 25000,
  parameter int WINDOW_MS  = 100
) (
  input  logic clk,
  input  logic rstPorN,
  input  logic swRst,
  input  logic pinIn,
  output logic pinEvt
);
  localparam int PRE_W = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
  localparam int MS_W  = (WINDOW_MS > 1) ? $clog2(WINDOW_MS) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_MS - 1);
  localparam logic [MS_W-1:0]  MS_LAST  = MS_W'(WINDOW_MS - 1);

  logic [1:0]      syncQ;
  logic            pinLvl;
  logic [PRE_W-1:0] preCnt;
  logic [MS_W-1:0]  msCnt;
  pin_phase_e      phase;
  logic            msTick;
  logic            lastMs;

  always_ff @(posedge clk or negedge rstPorN) begin
    if (!rstPorN) syncQ <= 2'b11;
    else          syncQ <= {syncQ[0], pinIn};
  end

  assign pinLvl = syncQ[1];
  assign msTick = (preCnt == PRE_LAST);
  assign lastMs = (msCnt == MS_LAST);

  always_ff @(posedge clk or negedge rstPorN) begin
    if (!rstPorN) begin
      phase  <= PH_LOW;
      preCnt <= '0;
      msCnt  <= '0;
      pinEvt <= 1'b0;
    end else if (swRst) begin
      phase  <= PH_LOW;
      preCnt <= '0;
      msCnt  <= '0;
      pinEvt <= 1'b0;
    end else begin
      pinEvt <= 1'b0;
      unique case (phase)
        PH_LOW: begin
          if (pinLvl) begin
            preCnt <= '0;
            msCnt  <= '0;
          end else if (msTick) begin
            preCnt <= '0;
            if (lastMs) begin
              msCnt <= '0;
              phase <= PH_ARMED;
            end else begin
              msCnt <= msCnt + 1'b1;
            end
          end else begin
            preCnt <= preCnt + 1'b1;
          end
        end
        PH_ARMED: begin
          if (pinLvl) phase <= PH_HIGH;
        end
        PH_HIGH: begin
          if (!pinLvl) begin
            preCnt <= '0;
            msCnt  <= '0;
            phase  <= PH_LOW;
          end else if (msTick) begin
            preCnt <= '0;
            if (lastMs) begin
              msCnt  <= '0;
              pinEvt <= 1'b1;
              phase  <= PH_LOW;
            end else begin
              msCnt <= msCnt + 1'b1;
            end
          end else begin
            preCnt <= preCnt + 1'b1;
          end
        end
        default: phase <= PH_LOW;
      endcase
    end
  end
endmodule

// File: rtl/wake_ctrl.sv
module wake_ctrl
  import wake_pkg::*;
(
  input  logic             swRst,
  input  logic             pinEvt,
  input  logic             linkEvt,
  input  logic             sampleEvt,
  input  logic             magicEvt,
  input  logic             regWr,
  input  logic [7:0]       regWdata,
  input  logic             clrStb,
  input  logic [NSRC-1:0]  clrMask,
  output wake_strb_t       strb
);
  logic [NSRC-1:0] evtVec;
  logic            unusedStatWr;

  always_comb begin
    evtVec             = '0;
    evtVec[SRC_PIN]    = pinEvt;
    evtVec[SRC_LINK]   = linkEvt;
    evtVec[SRC_SAMPLE] = sampleEvt;
    evtVec[SRC_MAGIC]  = magicEvt;
  end

  // status positions of the write byte are ignored
  assign unusedStatWr = ^{regWdata[6], regWdata[4], regWdata[2], regWdata[0]};

  always_comb begin
    strb.setStat  = evtVec;
    strb.clrStat  = clrStb ? clrMask : '0;
    strb.dropStat = swRst ? ~SOFT_KEEP : '0;
    strb.enLoad   = regWr;
    strb.enDrop   = swRst;
    for (int i = 0; i < NSRC; i++) strb.enVal[i] = regWdata[2*i+1];
  end
endmodule

// File: rtl/wake_datapath.sv
module wake_datapath
  import wake_pkg::*;
(
  input  logic       clk,
  input  logic       rstPorN,
  input  wake_strb_t strb,
  output logic [7:0] regRdata,
  output logic       wakeReq
);
  logic [NSRC-1:0] enReg;
  logic [NSRC-1:0] stReg;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_ff @(posedge clk or negedge rstPorN) begin
      if (!rstPorN)           enReg[i] <= 1'b0;
      else if (strb.enDrop)   enReg[i] <= 1'b0;
      else if (strb.enLoad)   enReg[i] <= strb.enVal[i];
    end

    always_ff @(posedge clk or negedge rstPorN) begin
      if (!rstPorN)               stReg[i] <= 1'b0;
      else if (strb.dropStat[i])  stReg[i] <= 1'b0;
      else if (strb.setStat[i])   stReg[i] <= 1'b1;
      else if (strb.clrStat[i])   stReg[i] <= 1'b0;
    end

    assign regRdata[2*i+1] = enReg[i];
    assign regRdata[2*i]   = stReg[i];
  end

  assign wakeReq = |(enReg & stReg);
endmodule

// File: rtl/wake_evt_ctrl.sv
module wake_evt_ctrl
  import wake_pkg::*;
#(
  parameter int CLK_PER_MS = 25000,
  parameter int WINDOW_MS  = 100
) (
  input  logic       clk,
  input  logic       rstPorN,
  input  logic       swRst,
  input  logic       pinIn,
  input  logic       linkEvt,
  input  logic       sampleEvt,
  input  logic       magicEvt,
  input  logic       regWr,
  input  logic [7:0] regWdata,
  input  logic       clrStb,
  input  logic [3:0] clrMask,
  output logic [7:0] regRdata,
  output logic       wakeReq
);
  logic       pinEvt;
  wake_strb_t strb;

  wake_pin_det #(.CLK_PER_MS(CLK_PER_MS), .WINDOW_MS(WINDOW_MS)) pin_det_i (
    .clk(clk), .rstPorN(rstPorN), .swRst(swRst), .pinIn(pinIn), .pinEvt(pinEvt)
  );

  wake_ctrl ctrl_i (
    .swRst(swRst), .pinEvt(pinEvt), .linkEvt(linkEvt), .sampleEvt(sampleEvt),
    .magicEvt(magicEvt), .regWr(regWr), .regWdata(regWdata), .clrStb(clrStb),
    .clrMask(clrMask), .strb(strb)
  );

  wake_datapath dp_i (
    .clk(clk), .rstPorN(rstPorN), .strb(strb), .regRdata(regRdata), .wakeReq(wakeReq)
  );
endmodule

// File: rtl/wake_evt_ctrl_chk.sv
module wake_evt_ctrl_chk (
  input logic       clk,
  input logic       rstPorN,
  input logic       swRst,
  input logic       pinIn,
  input logic       linkEvt,
  input logic       sampleEvt,
  input logic       magicEvt,
  input logic       regWr,
  input logic [7:0] regWdata,
  input logic       clrStb,
  input logic [3:0] clrMask,
  input logic [7:0] regRdata,
  input logic       wakeReq
);
  AST_WAKE_FROM_BYTE: assert property (@(posedge clk) disable iff (!rstPorN)
    wakeReq == ((regRdata[7] & regRdata[6]) | (regRdata[5] & regRdata[4]) |
                (regRdata[3] & regRdata[2]) | (regRdata[1] & regRdata[0]))); // R5

  AST_MAGIC_SETS: assert property (@(posedge clk) disable iff (!rstPorN)
    magicEvt |=> regRdata[0]); // R4

  AST_LINK_SETS: assert property (@(posedge clk) disable iff (!rstPorN)
    (linkEvt && !swRst) |=> regRdata[4]); // R4

  AST_EVT_BEATS_CLR: assert property (@(posedge clk) disable iff (!rstPorN)
    (sampleEvt && clrStb && clrMask[1]) |=> regRdata[2]); // R7

  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rstPorN)
    (clrStb && clrMask[2] && !linkEvt) |=> !regRdata[4]); // R6

  AST_SOFT_DROPS: assert property (@(posedge clk) disable iff (!rstPorN)
    swRst |=> ((regRdata & 8'hFA) == 8'h00)); // R8

  AST_SOFT_KEEPS: assert property (@(posedge clk) disable iff (!rstPorN)
    (swRst && !magicEvt && !(clrStb && clrMask[0])) |=> $stable(regRdata[0])); // R8

  AST_STAT_READ_ONLY: assert property (@(posedge clk) disable iff (!rstPorN)
    (regWr && !swRst && !clrStb && !linkEvt && !sampleEvt && !magicEvt)
      |=> $stable({regRdata[4], regRdata[2], regRdata[0]})); // R3
endmodule

bind wake_evt_ctrl wake_evt_ctrl_chk chk_i (.*);

// File: tb/wake_evt_ctrl_tb.sv
module wake_evt_ctrl_tb_top;
  localparam int CPM = 4;
  localparam int WMS = 5;

  logic       clk = 1'b0;
  logic       rstPorN = 1'b0;
  logic       swRst = 1'b0;
  logic       pinIn = 1'b1;
  logic       linkEvt = 1'b0, sampleEvt = 1'b0, magicEvt = 1'b0;
  logic       regWr = 1'b0;
  logic [7:0] regWdata = 8'h00;
  logic       clrStb = 1'b0;
  logic [3:0] clrMask = 4'h0;
  logic [7:0] regRdata;
  logic       wakeReq;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [3:0] mEn = 4'h0;
  logic [3:0] mSt = 4'h0;

  always #2 clk = ~clk;

  wake_evt_ctrl #(.CLK_PER_MS(CPM), .WINDOW_MS(WMS)) dut_i (
    .clk(clk), .rstPorN(rstPorN), .swRst(swRst), .pinIn(pinIn),
    .linkEvt(linkEvt), .sampleEvt(sampleEvt), .magicEvt(magicEvt),
    .regWr(regWr), .regWdata(regWdata), .clrStb(clrStb), .clrMask(clrMask),
    .regRdata(regRdata), .wakeReq(wakeReq)
  );

  function automatic logic [7:0] packByte(logic [3:0] en, logic [3:0] st);
    logic [7:0] b;
    for (int i = 0; i < 4; i++) begin
      b[2*i+1] = en[i];
      b[2*i]   = st[i];
    end
    return b;
  endfunction

  function automatic logic [3:0] nextSt(logic [3:0] st, logic sr, logic [3:0] ev,
                                        logic clr, logic [3:0] msk);
    logic [3:0] n;
    for (int i = 0; i < 4; i++) begin
      if (sr && i >= 2)        n[i] = 1'b0;
      else if (ev[i])          n[i] = 1'b1;
      else if (clr && msk[i])  n[i] = 1'b0;
      else                     n[i] = st[i];
    end
    return n;
  endfunction

  function automatic logic [3:0] nextEn(logic [3:0] en, logic sr, logic wr, logic [7:0] wd);
    if (sr) return 4'h0;
    if (wr) return {wd[7], wd[5], wd[3], wd[1]};
    return en;
  endfunction

  task automatic check(input string req);
    logic [7:0] expB;
    logic       expW;
    expB = packByte(mEn, mSt);
    expW = |(mEn & mSt);
    total++;
    if (regRdata !== expB || wakeReq !== expW) begin
      bad++;
      $display("FAIL %s: rdata=%h wake=%b expected rdata=%h wake=%b",
               req, regRdata, wakeReq, expB, expW);
    end
  endtask

  // called just after a negedge: drive one cycle, check after the edge
  task automatic cyc(input logic sr, input logic wr, input logic [7:0] wd,
                     input logic clr, input logic [3:0] msk, input logic [2:0] ev,
                     input string req);
    swRst = sr; regWr = wr; regWdata = wd; clrStb = clr; clrMask = msk;
    linkEvt = ev[2]; sampleEvt = ev[1]; magicEvt = ev[0];
    mSt = nextSt(mSt, sr, {1'b0, ev}, clr, msk);
    mEn = nextEn(mEn, sr, wr, wd);
    @(negedge clk);
    swRst = 1'b0; regWr = 1'b0; clrStb = 1'b0;
    linkEvt = 1'b0; sampleEvt = 1'b0; magicEvt = 1'b0;
    check(req);
  endtask

  task automatic pinHold(input logic lvl, input int n);
    pinIn = lvl;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #600000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0000_5eed));
    repeat (3) @(negedge clk);
    check("R1 reset state");
    rstPorN = 1'b1;
    @(negedge clk);
    check("R1 after release");

    cyc(0, 1, 8'hFF, 0, 4'h0, 3'b000, "R2 R3 enable write");
    cyc(0, 1, 8'h55, 0, 4'h0, 3'b000, "R3 status bits ignored on write");
    cyc(0, 1, 8'hAA, 0, 4'h0, 3'b000, "R2 enable reload");
    cyc(0, 0, 8'h00, 1, 4'h4, 3'b100, "R7 link event beats clear");
    cyc(0, 0, 8'h00, 1, 4'h4, 3'b000, "R6 clear link");
    cyc(0, 1, 8'h00, 0, 4'h0, 3'b011, "R4 events with enables off");
    cyc(0, 1, 8'h0A, 0, 4'h0, 3'b000, "R5 wake from enabled status");
    cyc(0, 0, 8'h00, 0, 4'h0, 3'b100, "R4 link status set");
    cyc(1, 0, 8'h00, 0, 4'h0, 3'b000, "R8 soft reset keeps sample magic");
    cyc(0, 0, 8'h00, 1, 4'h1, 3'b000, "R6 clear magic only");
    cyc(1, 1, 8'hFF, 0, 4'h0, 3'b101, "R8 soft reset beats link and write");

    // pin detection, enable pin source first
    cyc(0, 1, 8'h80, 0, 4'h0, 3'b000, "R2 pin enable");
    pinHold(1'b0, 12); pinHold(1'b1, 3); pinHold(1'b0, 12); pinHold(1'b1, 40);
    check("R10 broken low phase gives no event");
    pinHold(1'b0, 26); pinHold(1'b1, 10); pinHold(1'b0, 3); pinHold(1'b1, 40);
    check("R11 broken high phase gives no event");
    pinHold(1'b0, 26); pinHold(1'b1, 32);
    mSt[3] = 1'b1;
    check("R9 full low then high sets pin status");
    cyc(0, 0, 8'h00, 1, 4'h8, 3'b000, "R6 clear pin status");
    pinHold(1'b0, 26); pinHold(1'b1, 32);
    mSt[3] = 1'b1;
    check("R9 second pin event");
    cyc(1, 0, 8'h00, 0, 4'h0, 3'b000, "R8 soft reset clears pin");

    for (int k = 0; k < 4000; k++) begin
      logic sr, wr, clr;
      logic [7:0] wd;
      logic [3:0] msk;
      logic [2:0] ev;
      sr  = ($urandom % 16) == 0;
      wr  = ($urandom % 4) == 0;
      clr = ($urandom % 4) == 0;
      wd  = 8'($urandom);
      msk = 4'($urandom);
      ev  = {($urandom % 6) == 0, ($urandom % 6) == 0, ($urandom % 6) == 0};
      cyc(sr, wr, wd, clr, msk, ev, "R4 R5 R6 R7 R8 random");
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule